// File: doc/BRIEF.md
# Condition Register Logic Unit

This block holds a 32-bit condition register built from eight 4-bit fields, together with a small local exception register. Each cycle it may carry out one operation, selected by a 4-bit opcode and qualified by a valid strobe. The operations are:

- a masked write of whole fields from a data bus;
- a read that leaves the state untouched;
- a copy of one field into another;
- a transfer of the top nibble of the exception register into a field, which also clears that nibble;
- eight single-bit Boolean operations, each combining two chosen bits into a chosen destination bit.

Both registers are always visible on read ports. Numbering runs from the most significant end: field 0 is the top nibble and bit index 0 is the top bit. The exception register has its own write port, so software-visible state can be seeded and observed without going through the operation path.

Top module: `cond_reg_unit`

## Requirements
- R1: After reset, both `crOut` and `xerOut` read zero.
- R2: Opcode 1 writes fields from `wrData`. Field f occupies bits [31-4f:28-4f], and mask bit (7-f) of `fieldMask` enables it. Unmasked fields keep their value. With mask 0xFF, the next read returns `wrData` exactly, including the patterns 0xaaaaaaaa and 0x55555555.
- R3: Bit index i addresses register bit 31-i. A bit operation changes only the destination bit, which may equal either source. For example, with the register at 0x0000ffff, an AND of bits 16 and 17 into bit 0 gives 0x8000ffff.
- R4: Opcodes 8 to 15 select the bit function from the low three opcode bits. The encoding is 0 AND, 1 A AND NOT B, 2 OR, 3 A OR NOT B, 4 XOR, 5 NAND, 6 NOR, 7 XNOR, where A is bit `srcA` and B is bit `srcB`.
- R5: Opcode 2 copies field `srcField` into field `dstField` and leaves the other seven fields unchanged. Copying field 0 into field 4 of 0x01234567 gives 0x01230567, and copying field 7 into field 0 gives 0x71234567.
- R6: Opcode 3 loads exception bits [31:28] into field `dstField` and clears those four exception bits. The other 28 exception bits are kept. With 0xa0000000 loaded, the exception register reads zero afterwards.
- R7: When `xerWrEn` is high, `xerWrData` is written to the exception register. If a transfer happens in the same cycle, the field receives the old top nibble, and the exception register takes the written data with bits [31:28] cleared.
- R8: Every result appears on the read ports in the cycle after the operation, so a read in the operation's own cycle shows the old value. With `opValid` low, or with opcode 0 (read) or opcodes 4 to 7, the condition register does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Qualifies the operation in this cycle |
| opCode | input | 4 | Operation select |
| wrData | input | 32 | Data for a masked field write |
| fieldMask | input | 8 | Per-field write enables, bit 7 is field 0 |
| srcA | input | 5 | First source bit index (A) |
| srcB | input | 5 | Second source bit index (B) |
| dstBit | input | 5 | Destination bit index |
| srcField | input | 3 | Source field for a copy |
| dstField | input | 3 | Destination field for a copy or transfer |
| xerWrEn | input | 1 | Exception register write enable |
| xerWrData | input | 32 | Exception register write data |
| crOut | output | 32 | Condition register contents |
| xerOut | output | 32 | Exception register contents |

## Verification
Every operation updates a register at the clock edge that samples it, so each result is due exactly one edge after the stimulus. The bench drives inputs on the falling edge and compares at the next falling edge, which places every check one cycle after its stimulus. One check samples in the middle of an operation's own cycle to confirm the old value is still shown. The bench model advances at that same edge, so long sweeps of bit operations accumulate state and each result is compared in its own cycle.

// File: rtl/cru_pkg.sv
package cru_pkg;

  localparam logic [3:0] OP_READ  = 4'd0;
  localparam logic [3:0] OP_WRITE = 4'd1;
  localparam logic [3:0] OP_COPY  = 4'd2;
  localparam logic [3:0] OP_XFER  = 4'd3;

  typedef enum logic [2:0] {
    FN_AND  = 3'd0,
    FN_ANDC = 3'd1,
    FN_OR   = 3'd2,
    FN_ORC  = 3'd3,
    FN_XOR  = 3'd4,
    FN_NAND = 3'd5,
    FN_NOR  = 3'd6,
    FN_EQV  = 3'd7
  } bitFn_e;

  typedef struct packed {
    logic   wrEn;
    logic   copyEn;
    logic   xferEn;
    logic   bitEn;
    bitFn_e fn;
  } crStrobe_t;

  function automatic logic bitLogic(bitFn_e fn, logic a, logic b);
    logic r;
    unique case (fn)
      FN_AND:  r = a & b;
      FN_ANDC: r = a & ~b;
      FN_OR:   r = a | b;
      FN_ORC:  r = a | ~b;
      FN_XOR:  r = a ^ b;
      FN_NAND: r = ~(a & b);
      FN_NOR:  r = ~(a | b);
      default: r = ~(a ^ b);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cru_ctrl.sv
module cru_ctrl
  import cru_pkg::*;
(
  input  logic       opValid,
  input  logic [3:0] opCode,
  output crStrobe_t  strobe
);

  always_comb begin
    strobe        = '0;
    strobe.fn     = bitFn_e'(opCode[2:0]);
    if (opValid) begin
      if (opCode[3]) begin
        strobe.bitEn = 1'b1;
      end else begin
        unique case (opCode)
          OP_WRITE: strobe.wrEn   = 1'b1;
          OP_COPY:  strobe.copyEn = 1'b1;
          OP_XFER:  strobe.xferEn = 1'b1;
          default:  ;
        endcase
      end
    end
  end

endmodule

// File: rtl/cru_datapath.sv
module cru_datapath
  import cru_pkg::*;
#(
  parameter  int FIELDS  = 8,
  parameter  int FIELD_W = 4,
  localparam int CR_W    = FIELDS * FIELD_W,
  localparam int BIT_IW  = $clog2(CR_W),
  localparam int FLD_IW  = $clog2(FIELDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  crStrobe_t         strobe,
  input  logic [CR_W-1:0]   wrData,
  input  logic [FIELDS-1:0] fieldMask,
  input  logic [BIT_IW-1:0] srcA,
  input  logic [BIT_IW-1:0] srcB,
  input  logic [BIT_IW-1:0] dstBit,
  input  logic [FLD_IW-1:0] srcField,
  input  logic [FLD_IW-1:0] dstField,
  input  logic              xerWrEn,
  input  logic [CR_W-1:0]   xerWrData,
  output logic [CR_W-1:0]   crQ,
  output logic [CR_W-1:0]   xerQ
);

  logic [CR_W-1:0]    wrMerged;
  logic [CR_W-1:0]    crNext;
  logic [CR_W-1:0]    xerNext;
  logic [FIELD_W-1:0] srcNib;
  logic [FIELD_W-1:0] xerTop;
  logic               bitA, bitB, bitRes;
  int                 dstBase;

  // physical nibble k is field FIELDS-1-k and its enable is fieldMask[k]
  for (genvar k = 0; k < FIELDS; k++) begin : gMerge
    assign wrMerged[k*FIELD_W +: FIELD_W] =
      fieldMask[k] ? wrData[k*FIELD_W +: FIELD_W] : crQ[k*FIELD_W +: FIELD_W];
  end

  assign srcNib  = crQ[(FIELDS-1-int'(srcField))*FIELD_W +: FIELD_W];
  assign xerTop  = xerQ[CR_W-1 -: FIELD_W];
  assign dstBase = (FIELDS-1-int'(dstField))*FIELD_W;
  assign bitA    = crQ[CR_W-1-int'(srcA)];
  assign bitB    = crQ[CR_W-1-int'(srcB)];
  assign bitRes  = bitLogic(strobe.fn, bitA, bitB);

  always_comb begin
    crNext = crQ;
    if (strobe.wrEn) begin
      crNext = wrMerged;
    end else if (strobe.copyEn) begin
      crNext[dstBase +: FIELD_W] = srcNib;
    end else if (strobe.xferEn) begin
      crNext[dstBase +: FIELD_W] = xerTop;
    end else if (strobe.bitEn) begin
      crNext[CR_W-1-int'(dstBit)] = bitRes;
    end
  end

  always_comb begin
    xerNext = xerWrEn ? xerWrData : xerQ;
    if (strobe.xferEn) begin
      xerNext[CR_W-1 -: FIELD_W] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crQ  <= '0;
      xerQ <= '0;
    end else begin
      crQ  <= crNext;
      xerQ <= xerNext;
    end
  end

endmodule

// File: rtl/cond_reg_unit.sv
module cond_reg_unit
  import cru_pkg::*;
#(
  parameter  int FIELDS  = 8,
  parameter  int FIELD_W = 4,
  localparam int CR_W    = FIELDS * FIELD_W,
  localparam int BIT_IW  = $clog2(CR_W),
  localparam int FLD_IW  = $clog2(FIELDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [CR_W-1:0]   wrData,
  input  logic [FIELDS-1:0] fieldMask,
  input  logic [BIT_IW-1:0] srcA,
  input  logic [BIT_IW-1:0] srcB,
  input  logic [BIT_IW-1:0] dstBit,
  input  logic [FLD_IW-1:0] srcField,
  input  logic [FLD_IW-1:0] dstField,
  input  logic              xerWrEn,
  input  logic [CR_W-1:0]   xerWrData,
  output logic [CR_W-1:0]   crOut,
  output logic [CR_W-1:0]   xerOut
);

  crStrobe_t strobe;

  cru_ctrl uCtrl (
    .opValid (opValid),
    .opCode  (opCode),
    .strobe  (strobe)
  );

  cru_datapath #(
    .FIELDS  (FIELDS),
    .FIELD_W (FIELD_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .fieldMask (fieldMask),
    .srcA      (srcA),
    .srcB      (srcB),
    .dstBit    (dstBit),
    .srcField  (srcField),
    .dstField  (dstField),
    .xerWrEn   (xerWrEn),
    .xerWrData (xerWrData),
    .crQ       (crOut),
    .xerQ      (xerOut)
  );

endmodule

// File: rtl/cru_checker.sv
module cru_checker #(
  parameter  int FIELDS  = 8,
  parameter  int FIELD_W = 4,
  localparam int CR_W    = FIELDS * FIELD_W,
  localparam int BIT_IW  = $clog2(CR_W),
  localparam int FLD_IW  = $clog2(FIELDS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [3:0]        opCode,
  input logic [CR_W-1:0]   wrData,
  input logic [FIELDS-1:0] fieldMask,
  input logic [BIT_IW-1:0] dstBit,
  input logic [FLD_IW-1:0] srcField,
  input logic [FLD_IW-1:0] dstField,
  input logic              xerWrEn,
  input logic [CR_W-1:0]   xerWrData,
  input logic [CR_W-1:0]   crOut,
  input logic [CR_W-1:0]   xerOut
);

  function automatic logic [FIELD_W-1:0] fieldOf(logic [CR_W-1:0] v, int idx);
    return v[(FIELDS-1-idx)*FIELD_W +: FIELD_W];
  endfunction

  localparam logic [CR_W-1:0] TOP_BIT = {1'b1, {(CR_W-1){1'b0}}};

  a_r2_full_write: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 4'd1 && fieldMask == '1) |=> crOut == $past(wrData));

  a_r3_only_dest_bit: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode[3]) |=>
      ((crOut ^ $past(crOut)) & ~(TOP_BIT >> $past(dstBit))) == '0);

  a_r5_copy_field: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 4'd2) |=>
      fieldOf(crOut, int'($past(dstField))) == fieldOf($past(crOut), int'($past(srcField))));

  a_r6_xfer_clears: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 4'd3) |=> xerOut[CR_W-1 -: FIELD_W] == '0);

  a_r7_xer_write: assert property (@(posedge clk) disable iff (!rstN)
    (xerWrEn && !(opValid && opCode == 4'd3)) |=> xerOut == $past(xerWrData));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(crOut));

endmodule

bind cond_reg_unit cru_checker #(
  .FIELDS  (FIELDS),
  .FIELD_W (FIELD_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opCode    (opCode),
  .wrData    (wrData),
  .fieldMask (fieldMask),
  .dstBit    (dstBit),
  .srcField  (srcField),
  .dstField  (dstField),
  .xerWrEn   (xerWrEn),
  .xerWrData (xerWrData),
  .crOut     (crOut),
  .xerOut    (xerOut)
);

// File: tb/sim_cond_reg_unit.sv
module sim_cond_reg_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        opValid;
  logic [3:0]  opCode;
  logic [31:0] wrData;
  logic [7:0]  fieldMask;
  logic [4:0]  srcA, srcB, dstBit;
  logic [2:0]  srcField, dstField;
  logic        xerWrEn;
  logic [31:0] xerWrData;
  logic [31:0] crOut, xerOut;

  int   nChecks = 0;
  int   nFails  = 0;
  bit   finished = 0;
  logic [31:0] expCr, expXer;

  always #10 clk = ~clk;

  cond_reg_unit u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .wrData(wrData), .fieldMask(fieldMask), .srcA(srcA), .srcB(srcB),
    .dstBit(dstBit), .srcField(srcField), .dstField(dstField),
    .xerWrEn(xerWrEn), .xerWrData(xerWrData), .crOut(crOut), .xerOut(xerOut)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    opValid = 0; opCode = 0; xerWrEn = 0;
  endtask

  function automatic logic [31:0] putField(logic [31:0] v, int f, logic [3:0] n);
    logic [31:0] r = v;
    r[31-4*f -: 4] = n;
    return r;
  endfunction

  function automatic logic [3:0] getField(logic [31:0] v, int f);
    return v[31-4*f -: 4];
  endfunction

  function automatic logic fnModel(int fn, logic a, logic b);
    case (fn)
      0: return a & b;
      1: return a & !b;
      2: return a | b;
      3: return a | !b;
      4: return a ^ b;
      5: return !(a & b);
      6: return !(a | b);
      default: return a == b;
    endcase
  endfunction

  task automatic doWrite(logic [31:0] d, logic [7:0] m);
    opValid = 1; opCode = 4'd1; wrData = d; fieldMask = m;
    step();
    for (int f = 0; f < 8; f++)
      if (m[7-f]) expCr = putField(expCr, f, getField(d, f));
    idle();
  endtask

  task automatic doCopy(int s, int d);
    opValid = 1; opCode = 4'd2; srcField = 3'(s); dstField = 3'(d);
    step();
    expCr = putField(expCr, d, getField(expCr, s));
    idle();
  endtask

  task automatic doXerWrite(logic [31:0] d);
    xerWrEn = 1; xerWrData = d;
    step();
    expXer = d;
    idle();
  endtask

  task automatic doXfer(int d);
    opValid = 1; opCode = 4'd3; dstField = 3'(d);
    step();
    expCr  = putField(expCr, d, expXer[31:28]);
    expXer = {4'h0, expXer[27:0]};
    idle();
  endtask

  task automatic doBit(int fn, int a, int b, int d);
    logic r;
    opValid = 1; opCode = 4'(8 + fn); srcA = 5'(a); srcB = 5'(b); dstBit = 5'(d);
    step();
    r = fnModel(fn, expCr[31-a], expCr[31-b]);
    expCr[31-d] = r;
    idle();
  endtask

  initial begin
    rstN = 0; idle();
    wrData = 0; fieldMask = 0; srcA = 0; srcB = 0; dstBit = 0;
    srcField = 0; dstField = 0; xerWrData = 0;
    expCr = 0; expXer = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 cr reset", crOut, 32'h0);
    chk("R1 xer reset", xerOut, 32'h0);

    // R2 full writes of alternating patterns
    doWrite(32'haaaaaaaa, 8'hff); chk("R2 aaaa readback", crOut, 32'haaaaaaaa);
    doWrite(32'h55555555, 8'hff); chk("R2 5555 readback", crOut, 32'h55555555);

    // R8 old value during the write cycle, new value after
    opValid = 1; opCode = 4'd1; wrData = 32'h12345678; fieldMask = 8'hff;
    #2 chk("R8 old value in op cycle", crOut, 32'h55555555);
    step(); expCr = 32'h12345678; idle();
    chk("R8 new value next cycle", crOut, 32'h12345678);

    // R2 masked write sweep over every mask
    for (int m = 0; m < 256; m++) begin
      doWrite(32'h9e3779b9 * (m + 3), 8'(m));
      chk("R2 masked write", crOut, expCr);
    end

    // R5 doc examples then every pair
    doWrite(32'h01234567, 8'hff); doCopy(0, 4);
    chk("R5 copy 0 to 4", crOut, 32'h01230567);
    doWrite(32'h01234567, 8'hff); doCopy(7, 0);
    chk("R5 copy 7 to 0", crOut, 32'h71234567);
    for (int s = 0; s < 8; s++)
      for (int d = 0; d < 8; d++) begin
        doWrite(32'h89abcdef ^ (32'h01010101 * s), 8'hff);
        doCopy(s, d);
        chk("R5 copy sweep", crOut, expCr);
      end

    // R6 transfer
    doWrite(32'hffffffff, 8'hff);
    doXerWrite(32'ha0000000); chk("R7 xer write", xerOut, 32'ha0000000);
    doXfer(7);
    chk("R6 xfer field", crOut, 32'hfffffffa);
    chk("R6 xer cleared", xerOut, 32'h0);
    for (int d = 0; d < 8; d++) begin
      doXerWrite(32'h4000_0000 + 32'h1000_0000 * d + 32'h0badcafe);
      doXfer(d);
      chk("R6 xfer sweep cr", crOut, expCr);
      chk("R6 xfer sweep xer", xerOut, expXer);
    end

    // R7 simultaneous exception write and transfer
    doXerWrite(32'h50000000);
    opValid = 1; opCode = 4'd3; dstField = 3'd2; xerWrEn = 1; xerWrData = 32'hf1234567;
    step(); idle();
    expCr = putField(expCr, 2, 4'h5);
    chk("R7 xfer uses old xer", crOut, expCr);
    chk("R7 clear beats write", xerOut, 32'h01234567);

    // R3 doc example
    doWrite(32'h0000ffff, 8'hff); doBit(0, 16, 17, 0);
    chk("R3 and 16,17 into 0", crOut, 32'h8000ffff);
    doWrite(32'h0000ffff, 8'hff); doBit(1, 16, 0, 0);
    chk("R4 andc", crOut, 32'h8000ffff);
    doWrite(32'h0000ffff, 8'hff); doBit(7, 0, 0, 0);
    chk("R4 eqv", crOut, 32'h8000ffff);

    // R3 R4 sweep of all functions, all first sources, dest may alias
    for (int fn = 0; fn < 8; fn++)
      for (int a = 0; a < 32; a++) begin
        doWrite(32'h9e3779b9 * (a + fn * 32 + 1), 8'hff);
        for (int k = 0; k < 4; k++) begin
          int b = (a * 7 + k * 5 + fn) % 32;
          int d = (k == 0) ? a : (k == 1) ? b : (a + b + fn * 3) % 32;
          doBit(fn, a, b, d);
          chk("R4 bit op sweep", crOut, expCr);
        end
      end

    // R8 ignored operations
    doWrite(32'hcafef00d, 8'hff);
    opValid = 0; opCode = 4'd1; wrData = 32'h0; fieldMask = 8'hff;
    step(); idle();
    chk("R8 valid low write ignored", crOut, 32'hcafef00d);
    opValid = 0; opCode = 4'd8; srcA = 1; srcB = 2; dstBit = 0;
    step(); idle();
    chk("R8 valid low bit op ignored", crOut, 32'hcafef00d);
    for (int c = 4; c < 8; c++) begin
      opValid = 1; opCode = 4'(c); step(); idle();
      chk("R8 reserved opcode", crOut, 32'hcafef00d);
    end
    opValid = 1; opCode = 4'd0; step(); idle();
    chk("R8 read op no change", crOut, 32'hcafef00d);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule